// File: doc/BRIEF.md
# Counter-Based LRU Replacement Unit

This unit keeps the recency order of every set in a set-associative cache and names the way to replace when a miss has to bring in a new block. Each way of each set holds a small age counter. Age 0 marks the most recently used way and age WAYS-1 the least recently used one. A valid flag per way records whether the way holds a block. The tag and data arrays stay in the surrounding cache. This unit only ranks the ways.

The cache controller drives the set index on `acc_set` with every strobe. An access strobe with `acc_hit` high and a way number promotes that way. An access strobe with `acc_hit` low is a plain lookup and changes nothing. A fill strobe installs a new block in the addressed set. An empty way is used while one is left; once the set is full, the oldest way is used. One clock after any strobe, the registered outputs give the replacement candidate and the full flag of the addressed set, with the update from that strobe already applied.

Top module: `lru_repl_unit`

## Requirements
- R1: A synchronous active-high reset marks every way of every set empty, and the clock edge that samples reset drives `victim_o` to 0 and `full_o` to 0.
- R2: A hit on a valid way gives that way age 0. Valid ways that were younger than it age by one, and all other ways keep their age.
- R3: A fill into a set that has an empty way places the block in the lowest-numbered empty way with age 0. Every other valid way in that set ages by one.
- R4: A fill into a full set replaces the way of age WAYS-1, gives it age 0, and ages every other way by one.
- R5: One clock after a strobe (`acc_vld` or `fill_vld`), `victim_o` shows the binary way index that the next fill to `acc_set` would use, and `full_o` shows whether all ways of that set are valid. Both reflect the strobe's own update. Without a strobe, both outputs hold.
- R6: An access with `acc_hit` low changes no state.
- R7: A hit that names an empty way changes no state.
- R8: Sets are independent: a strobe changes only the set it addresses.
- R9: In a full set the ages always form a permutation of 0 to WAYS-1.
- R10: With four ways, the block sequence 17, 25, 17, 55, 25, 30, 22, 30 in one set evicts block 17 on the access to 22. It leaves the order 30, 22, 25, 55 from most to least recent, so the way holding 55 is the candidate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe (hit update or lookup) |
| acc_set | input | $clog2(SETS) | Set addressed by the current strobe |
| acc_hit | input | 1 | Access is a hit on `acc_way` |
| acc_way | input | $clog2(WAYS) | Way that hit |
| fill_vld | input | 1 | Install a block in set `acc_set` |
| victim_o | output | $clog2(WAYS) | Registered replacement candidate of the last addressed set |
| full_o | output | 1 | Registered flag: last addressed set has no empty way |

## Verification
An update to the ages and the choice of the next candidate fall in the same clock for the same set. This holds for a hit, and for a fill, whose own target is picked from the old ages while the reported candidate must come from the new ones. The bench provokes this with back-to-back hits and fills on one set, and also with fills that turn a set full or that replace its oldest way. A queue-based model of each set, ordered from most to least recent, judges every clock. The model applies the strobe first and then derives the candidate. Random mixes also send hits to empty ways and interleave other sets, so a stale or cross-set candidate would show at the ports.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_HIT  = 2'd1,
    OP_FILL = 2'd2
  } lru_op_e;
endpackage

// File: rtl/lru_way_next.sv
module lru_way_next
  import lru_pkg::*;
#(
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  lru_op_e          op_i,
  input  logic             sel_i,
  input  logic             vld_i,
  input  logic [WAY_W-1:0] cnt_i,
  input  logic [WAY_W-1:0] ref_i,
  output logic             vld_o,
  output logic [WAY_W-1:0] cnt_o
);
  localparam logic [WAY_W-1:0] ONE = 1;

  always_comb begin
    vld_o = vld_i;
    cnt_o = cnt_i;
    case (op_i)
      OP_HIT: begin
        if (sel_i) cnt_o = '0;
        else if (vld_i && (cnt_i < ref_i)) cnt_o = cnt_i + ONE;
      end
      OP_FILL: begin
        if (sel_i) begin
          cnt_o = '0;
          vld_o = 1'b1;
        end else if (vld_i) begin
          cnt_o = cnt_i + ONE;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lru_pick.sv
module lru_pick #(
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS*WAY_W-1:0] cnt_i,
  input  logic [WAYS-1:0]       vld_i,
  output logic [WAY_W-1:0]      victim_o
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] empty_idx;
  logic [WAY_W-1:0] old_idx;

  always_comb begin
    empty_idx = '0;
    old_idx   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_i[w]) empty_idx = WAY_W'(w);
      if (cnt_i[w*WAY_W +: WAY_W] == OLDEST) old_idx = WAY_W'(w);
    end
    victim_o = (&vld_i) ? old_idx : empty_idx;
  end
endmodule

// File: rtl/lru_repl_unit.sv
module lru_repl_unit
  import lru_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_vld,
  output logic [WAY_W-1:0] victim_o,
  output logic             full_o
);
  logic [WAYS*WAY_W-1:0] cnt_q [SETS];
  logic [WAYS-1:0]       vld_q [SETS];

  logic [WAYS*WAY_W-1:0] cur_cnt;
  logic [WAYS-1:0]       cur_vld;
  logic [WAYS*WAY_W-1:0] nxt_cnt;
  logic [WAYS-1:0]       nxt_vld;
  logic [WAY_W-1:0]      fill_way;
  logic [WAY_W-1:0]      nxt_victim;
  logic [WAY_W-1:0]      ref_cnt;
  lru_op_e               op;

  assign cur_cnt = cnt_q[acc_set];
  assign cur_vld = vld_q[acc_set];
  assign ref_cnt = cur_cnt[acc_way*WAY_W +: WAY_W];

  always_comb begin
    if (fill_vld)                                  op = OP_FILL;
    else if (acc_vld && acc_hit && cur_vld[acc_way]) op = OP_HIT;
    else                                           op = OP_NONE;
  end

  lru_pick #(.WAYS(WAYS)) u_pick_fill (
    .cnt_i(cur_cnt), .vld_i(cur_vld), .victim_o(fill_way)
  );

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    logic sel;
    assign sel = (op == OP_FILL) ? (fill_way == WAY_W'(i)) : (acc_way == WAY_W'(i));
    lru_way_next #(.WAYS(WAYS)) u_next (
      .op_i (op),
      .sel_i(sel),
      .vld_i(cur_vld[i]),
      .cnt_i(cur_cnt[i*WAY_W +: WAY_W]),
      .ref_i(ref_cnt),
      .vld_o(nxt_vld[i]),
      .cnt_o(nxt_cnt[i*WAY_W +: WAY_W])
    );
  end

  lru_pick #(.WAYS(WAYS)) u_pick_out (
    .cnt_i(nxt_cnt), .vld_i(nxt_vld), .victim_o(nxt_victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        cnt_q[s] <= '0;
      end
    end else if (op != OP_NONE) begin
      vld_q[acc_set] <= nxt_vld;
      cnt_q[acc_set] <= nxt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_o <= '0;
      full_o   <= 1'b0;
    end else if (acc_vld || fill_vld) begin
      victim_o <= nxt_victim;
      full_o   <= &nxt_vld;
    end
  end
endmodule

// File: rtl/lru_repl_chk.sv
module lru_repl_chk #(
  parameter int WAYS  = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_vld,
  input logic                  acc_hit,
  input logic [WAY_W-1:0]      acc_way,
  input logic                  fill_vld,
  input logic [WAY_W-1:0]      victim_o,
  input logic                  full_o,
  input logic [WAYS-1:0]       cur_vld,
  input logic [WAYS-1:0]       nxt_vld,
  input logic [WAYS*WAY_W-1:0] nxt_cnt
);
  logic [WAYS-1:0] seen;

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[nxt_cnt[w*WAY_W +: WAY_W]] = 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (victim_o == '0 && !full_o));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!acc_vld && !fill_vld) |=> ($stable(victim_o) && $stable(full_o)));

  a_r2_hit_not_victim: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_hit && !fill_vld && cur_vld[acc_way]) |=> (victim_o != $past(acc_way)));

  a_r9_full_perm: assert property (@(posedge clk) disable iff (rst)
    ((acc_vld || fill_vld) && (&nxt_vld)) |-> (seen == {WAYS{1'b1}}));

  a_r3_fill_marks_valid: assert property (@(posedge clk) disable iff (rst)
    (fill_vld && !(&cur_vld)) |-> ($countones(nxt_vld) == $countones(cur_vld) + 1));
endmodule

bind lru_repl_unit lru_repl_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/tb_lru_repl_unit.sv
`timescale 1ns/1ps
module tb_lru_repl_unit;
  localparam int K  = 4;
  localparam int NS = 32;
  localparam int WW = 2;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_vld = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic          acc_hit = 1'b0;
  logic [WW-1:0] acc_way = '0;
  logic          fill_vld = 1'b0;
  logic [WW-1:0] victim_o;
  logic          full_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int q [NS][$];
  int exp_vic = 0;
  int exp_full = 0;

  always #2 clk = ~clk;

  lru_repl_unit #(.WAYS(K), .SETS(NS)) dut (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_set(acc_set), .acc_hit(acc_hit),
    .acc_way(acc_way), .fill_vld(fill_vld), .victim_o(victim_o), .full_o(full_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find(int s, int w);
    for (int i = 0; i < q[s].size(); i++) if (q[s][i] == w) return i;
    return -1;
  endfunction

  function automatic int lowest_free(int s);
    for (int w = 0; w < K; w++) if (find(s, w) < 0) return w;
    return -1;
  endfunction

  function automatic int model_victim(int s);
    if (q[s].size() < K) return lowest_free(s);
    return q[s][q[s].size()-1];
  endfunction

  task automatic model_step(bit av, bit ht, int way, bit fv, int s);
    int idx;
    int w;
    if (fv) begin
      if (q[s].size() < K) w = lowest_free(s);
      else w = q[s].pop_back();
      q[s].push_front(w);
    end else if (av && ht) begin
      idx = find(s, way);
      if (idx >= 0) begin
        q[s].delete(idx);
        q[s].push_front(way);
      end
    end
    if (av || fv) begin
      exp_vic  = model_victim(s);
      exp_full = (q[s].size() == K) ? 1 : 0;
    end
  endtask

  // one clocked strobe; model compared on every clock (R5)
  task automatic cyc(bit av, bit ht, int way, bit fv, int s);
    acc_vld  = av;
    acc_hit  = ht;
    acc_way  = WW'(way);
    fill_vld = fv;
    acc_set  = SW'(s);
    @(posedge clk);
    model_step(av, ht, way, fv, s);
    @(negedge clk);
    check("R5 victim vs model", int'(victim_o), exp_vic);
    check("R5 full vs model", int'(full_o), exp_full);
    acc_vld  = 1'b0;
    acc_hit  = 1'b0;
    fill_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    for (int s = 0; s < NS; s++) q[s].delete();
    exp_vic = 0;
    exp_full = 0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset victim", int'(victim_o), 0);
    check("R1 reset full", int'(full_o), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tagw [K];
    bit tv [K];
    int evicted;
    int seq [8];
    do_reset();

    // R3: fills into an empty set take the lowest empty way
    cyc(1, 0, 0, 0, 5);
    check("R1 lookup after reset victim", int'(victim_o), 0);
    cyc(0, 0, 0, 1, 5);
    check("R3 first fill victim", int'(victim_o), 1);
    cyc(0, 0, 0, 1, 5);
    cyc(0, 0, 0, 1, 5);
    check("R3 third fill victim", int'(victim_o), 3);
    check("R3 not yet full", int'(full_o), 0);
    cyc(0, 0, 0, 1, 5);
    check("R3 full after four fills", int'(full_o), 1);
    check("R3 oldest is way 0", int'(victim_o), 0);

    // R2: hit promotion
    cyc(1, 1, 0, 0, 5);
    check("R2 hit way0 victim", int'(victim_o), 1);
    cyc(1, 1, 2, 0, 5);
    check("R2 hit way2 victim", int'(victim_o), 1);
    cyc(1, 1, 1, 0, 5);
    check("R2 hit way1 victim", int'(victim_o), 3);

    // R4: fill into full set replaces oldest
    cyc(0, 0, 0, 1, 5);
    check("R4 replace way3 then victim", int'(victim_o), 0);
    check("R4 still full", int'(full_o), 1);

    // R6: lookup leaves state
    cyc(1, 0, 2, 0, 5);
    cyc(1, 0, 1, 0, 5);
    check("R6 lookup no change", int'(victim_o), 0);

    // R8: other set untouched
    cyc(1, 0, 0, 0, 7);
    check("R8 other set empty victim", int'(victim_o), 0);
    check("R8 other set not full", int'(full_o), 0);
    // R5: outputs hold without strobe
    @(negedge clk);
    check("R5 hold victim", int'(victim_o), 0);

    // R7: hit to empty way ignored
    cyc(0, 0, 0, 1, 6);
    cyc(1, 1, 2, 0, 6);
    check("R7 empty-way hit victim", int'(victim_o), 1);
    check("R7 empty-way hit full", int'(full_o), 0);
    cyc(0, 0, 0, 1, 6);
    check("R7 next fill lands way1", int'(victim_o), 2);

    // R10: reference block sequence in set 9
    seq = '{17, 25, 17, 55, 25, 30, 22, 30};
    for (int w = 0; w < K; w++) tv[w] = 1'b0;
    evicted = -1;
    foreach (seq[n]) begin
      int hw;
      int tw;
      hw = -1;
      for (int w = 0; w < K; w++) if (tv[w] && tagw[w] == seq[n]) hw = w;
      if (hw >= 0) begin
        cyc(1, 1, hw, 0, 9);
      end else begin
        cyc(1, 0, 0, 0, 9);
        tw = int'(victim_o);
        if (seq[n] == 22) evicted = tv[tw] ? tagw[tw] : -1;
        cyc(0, 0, 0, 1, 9);
        tagw[tw] = seq[n];
        tv[tw] = 1'b1;
      end
    end
    check("R10 evicted block", evicted, 17);
    check("R10 candidate holds 55", tagw[victim_o], 55);
    check("R10 order pos0", tagw[q[9][0]], 30);
    check("R10 order pos1", tagw[q[9][1]], 22);
    check("R10 order pos2", tagw[q[9][2]], 25);

    // random mix across a few sets (R2, R3, R4, R6, R7, R8)
    for (int n = 0; n < 4000; n++) begin
      int r;
      int s;
      r = $urandom_range(0, 9);
      s = ($urandom_range(0, 7) == 0) ? 31 : $urandom_range(0, 3);
      if (r < 4)      cyc(1, 1, $urandom_range(0, K-1), 0, s);
      else if (r < 7) cyc(0, 0, 0, 1, s);
      else if (r < 9) cyc(1, 0, $urandom_range(0, K-1), 0, s);
      else begin
        @(negedge clk);
        check("R5 idle hold", int'(victim_o), exp_vic);
      end
    end

    // R1: reset mid-run empties a previously full set
    do_reset();
    cyc(1, 0, 0, 0, 5);
    check("R1 set5 empty after reset", int'(full_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule